// File: doc/BRIEF.md
# Engine Execution Control Unit

This block sits between a host bus and a small execution engine. The host never addresses the engine's instruction store, data store or context registers directly. It uses three host-visible registers instead: a data register, an address register and a combined command/status register. To write an engine location, the host loads the data register, then the address register, then writes a command code. To read a location, the host loads the address, issues the read command and collects the result from the data register after a fixed two-cycle delay. A fourth register counts retired instructions.

The engine itself is a stub. It retires one instruction on every cycle while it runs, or one instruction per single-step command while it is halted. Each retirement advances the next-PC field of context entry 0 and marks the pipeline as no longer clean. Reading the command/status address returns four status flags: running, halted, profile counter at zero, and pipeline clean.

The bus is synchronous. Writes are accepted on the rising clock edge when `bus_en` and `bus_we` are high. Read data is combinational from `bus_sel`. The command code is taken from the low 8 bits of the write data.

Top module: `engine_exec_ctrl`

## Requirements
- R1: After reset, the status word reads 0x60800000 (halted, profile zero, pipeline clean), and the data, address and retire-count registers read 0.
- R2: `bus_sel` selects the register: 0 is the data register, 1 is the address register, 2 is the status (read) and command (write) register, and 3 is the retire count. The data and address registers read back the last value written to them.
- R3: The write codes 0x11, 0x13 and 0x15 store the data register into instruction memory, data memory or context entry. The read codes 0x10, 0x12 and 0x14 fetch from the same three stores. In both cases the address register selects the word, modulo the store depth of 16 words.
- R4: After the edge that accepts a read command, the data register keeps its old value for one more edge. It takes the fetched word at the second edge after the command.
- R5: Command 0x02 sets status bit 31 (running) and clears bit 30 (halted) at its accepting edge. Command 0x03 does the reverse.
- R6: While the engine runs, the retire count rises by 1 at every edge, including the edge that accepts a stop command. While halted, it does not change.
- R7: Command 0x01 while halted retires exactly one instruction at its accepting edge. A step while running adds nothing beyond the normal run increment.
- R8: Each retirement increments the 13-bit next-PC field, bits [28:16] of context entry 0, with wrap-around. All other bits of that entry are preserved. A host write to entry 0 on the same edge takes priority.
- R9: Command 0x04 sets status bit 23 (pipeline clean). Any retirement clears it, but the command wins if both happen on the same edge.
- R10: An internal profile counter rises on every running cycle. Status bit 29 reads 1 exactly when the counter is zero. Command 0x0C zeroes the counter.
- R11: A host write to `bus_sel` 3 loads the retire count and overrides a same-edge increment.
- R12: A write of any other command code, such as 0x00 or 0x55, changes neither the status word nor the retire count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 32 | Write data; command code in bits [7:0] |
| bus_rdata | output | 32 | Read data of the selected register |

## Verification
The hardest case to reach is the next-PC wrap-around. Stepping 8191 times would be slow, so the bench first writes context entry 0 through the indirect write path with the PC field set to all ones, along with the active and load-duration bits. It then issues one step and reads the entry back through the indirect read path. The bench also pins down the step-while-running case by placing start, step and stop on three consecutive edges, so the exact count separates an ignored step from a counted one. The read latency is observed on the data register itself, one and two edges after the command.

// File: rtl/eec_pkg.sv
package eec_pkg;
    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
    localparam logic [1:0] SEL_WCNT = 2'd3;

    localparam logic [7:0] OP_STEP    = 8'h01;
    localparam logic [7:0] OP_START   = 8'h02;
    localparam logic [7:0] OP_STOP    = 8'h03;
    localparam logic [7:0] OP_CLRPIPE = 8'h04;
    localparam logic [7:0] OP_CLRPROF = 8'h0C;
    localparam logic [7:0] OP_RD_IMEM = 8'h10;
    localparam logic [7:0] OP_WR_IMEM = 8'h11;
    localparam logic [7:0] OP_RD_DMEM = 8'h12;
    localparam logic [7:0] OP_WR_DMEM = 8'h13;
    localparam logic [7:0] OP_RD_CTX  = 8'h14;
    localparam logic [7:0] OP_WR_CTX  = 8'h15;

    localparam int ST_RUN  = 31;
    localparam int ST_HALT = 30;
    localparam int ST_PZ   = 29;
    localparam int ST_PIPE = 23;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_IMEM = 2'd1,
        SP_DMEM = 2'd2,
        SP_CTX  = 2'd3
    } space_e;
endpackage

// File: rtl/eec_store.sv
module eec_store #(
    parameter int AW       = 4,
    parameter int DW       = 32,
    parameter bit TRACK_PC = 1'b0,
    parameter int PC_LSB   = 16,
    parameter int PC_W     = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          adv
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] slot0_adv;

    generate
        if (TRACK_PC) begin : g_pc
            always_comb begin
                slot0_adv = mem_q[0];
                slot0_adv[PC_LSB +: PC_W] = mem_q[0][PC_LSB +: PC_W] + 1'b1;
            end
        end else begin : g_plain
            always_comb slot0_adv = mem_q[0];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (adv) mem_d[0] = slot0_adv;
        if (we)  mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eec_exec.sv
module eec_exec
    import eec_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PROF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic             wcnt_we,
    input  logic [CNT_W-1:0] wcnt_wdata,
    output logic             running,
    output logic             pipe_clean,
    output logic             prof_zero,
    output logic             retire,
    output logic [CNT_W-1:0] wcnt
);
    typedef struct packed {
        logic              run;
        logic              pipe;
        logic [PROF_W-1:0] prof;
        logic [CNT_W-1:0]  cnt;
    } exec_t;

    exec_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        retire = st_q.run || (cmd_valid && cmd_code == OP_STEP);
        if (retire) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.pipe = 1'b0;
        end
        if (st_q.run) st_d.prof = st_q.prof + 1'b1;
        if (cmd_valid) begin
            case (cmd_code)
                OP_START:   st_d.run  = 1'b1;
                OP_STOP:    st_d.run  = 1'b0;
                OP_CLRPIPE: st_d.pipe = 1'b1;
                OP_CLRPROF: st_d.prof = '0;
                default:    ;
            endcase
        end
        if (wcnt_we) st_d.cnt = wcnt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, pipe: 1'b1, prof: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running    = st_q.run;
    assign pipe_clean = st_q.pipe;
    assign prof_zero  = (st_q.prof == '0);
    assign wcnt       = st_q.cnt;
endmodule

// File: rtl/engine_exec_ctrl.sv
module engine_exec_ctrl
    import eec_pkg::*;
#(
    parameter int IMEM_AW = 4,
    parameter int DMEM_AW = 4,
    parameter int CTX_AW  = 4,
    parameter int PROF_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [1:0]  bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int DW     = 32;
    localparam int MAX_A  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW;
    localparam int MAXAW  = (MAX_A > CTX_AW) ? MAX_A : CTX_AW;

    typedef struct packed {
        logic [DW-1:0]    xdata;
        logic [DW-1:0]    xaddr;
        logic             rd1;
        space_e           sp1;
        logic [MAXAW-1:0] a1;
        logic             rd2;
        logic [DW-1:0]    v2;
    } top_t;

    top_t st_d, st_q;

    logic          is_wr, is_cmd;
    logic [7:0]    code;
    logic          imem_we, dmem_we, ctx_we;
    logic          rd_req;
    space_e        rd_sp;
    logic [DW-1:0] imem_rd, dmem_rd, ctx_rd;
    logic          run_w, pipe_w, profz_w, retire_w;
    logic [DW-1:0] wcnt_w;
    logic [DW-1:0] status_w;

    assign is_wr   = bus_en && bus_we;
    assign is_cmd  = is_wr && (bus_sel == SEL_CMD);
    assign code    = bus_wdata[7:0];
    assign imem_we = is_cmd && (code == OP_WR_IMEM);
    assign dmem_we = is_cmd && (code == OP_WR_DMEM);
    assign ctx_we  = is_cmd && (code == OP_WR_CTX);

    always_comb begin
        rd_req = 1'b0;
        rd_sp  = SP_NONE;
        if (is_cmd) begin
            case (code)
                OP_RD_IMEM: begin rd_req = 1'b1; rd_sp = SP_IMEM; end
                OP_RD_DMEM: begin rd_req = 1'b1; rd_sp = SP_DMEM; end
                OP_RD_CTX:  begin rd_req = 1'b1; rd_sp = SP_CTX;  end
                default:    ;
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.rd1 = rd_req;
        st_d.sp1 = rd_sp;
        st_d.a1  = st_q.xaddr[MAXAW-1:0];
        st_d.rd2 = st_q.rd1;
        case (st_q.sp1)
            SP_IMEM: st_d.v2 = imem_rd;
            SP_DMEM: st_d.v2 = dmem_rd;
            SP_CTX:  st_d.v2 = ctx_rd;
            default: st_d.v2 = '0;
        endcase
        if (is_wr && bus_sel == SEL_DATA) st_d.xdata = bus_wdata;
        if (is_wr && bus_sel == SEL_ADDR) st_d.xaddr = bus_wdata;
        if (st_q.rd2) st_d.xdata = st_q.v2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{xdata: '0, xaddr: '0, rd1: 1'b0, sp1: SP_NONE,
                      a1: '0, rd2: 1'b0, v2: '0};
        end else begin
            st_q <= st_d;
        end
    end

    eec_store #(.AW(IMEM_AW), .DW(DW), .TRACK_PC(1'b0)) i_imem (
        .clk(clk), .rst_n(rst_n), .we(imem_we),
        .waddr(st_q.xaddr[IMEM_AW-1:0]), .wdata(st_q.xdata),
        .raddr(st_q.a1[IMEM_AW-1:0]), .rdata(imem_rd), .adv(1'b0)
    );

    eec_store #(.AW(DMEM_AW), .DW(DW), .TRACK_PC(1'b0)) i_dmem (
        .clk(clk), .rst_n(rst_n), .we(dmem_we),
        .waddr(st_q.xaddr[DMEM_AW-1:0]), .wdata(st_q.xdata),
        .raddr(st_q.a1[DMEM_AW-1:0]), .rdata(dmem_rd), .adv(1'b0)
    );

    eec_store #(.AW(CTX_AW), .DW(DW), .TRACK_PC(1'b1), .PC_LSB(16), .PC_W(13)) i_ctx (
        .clk(clk), .rst_n(rst_n), .we(ctx_we),
        .waddr(st_q.xaddr[CTX_AW-1:0]), .wdata(st_q.xdata),
        .raddr(st_q.a1[CTX_AW-1:0]), .rdata(ctx_rd), .adv(retire_w)
    );

    eec_exec #(.CNT_W(DW), .PROF_W(PROF_W)) i_exec (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(is_cmd), .cmd_code(code),
        .wcnt_we(is_wr && bus_sel == SEL_WCNT), .wcnt_wdata(bus_wdata),
        .running(run_w), .pipe_clean(pipe_w), .prof_zero(profz_w),
        .retire(retire_w), .wcnt(wcnt_w)
    );

    always_comb begin
        status_w          = '0;
        status_w[ST_RUN]  = run_w;
        status_w[ST_HALT] = !run_w;
        status_w[ST_PZ]   = profz_w;
        status_w[ST_PIPE] = pipe_w;
    end

    always_comb begin
        case (bus_sel)
            SEL_DATA: bus_rdata = st_q.xdata;
            SEL_ADDR: bus_rdata = st_q.xaddr;
            SEL_CMD:  bus_rdata = status_w;
            default:  bus_rdata = wcnt_w;
        endcase
    end
endmodule

// File: rtl/eec_checker.sv
module eec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [1:0]  bus_sel,
    input logic [31:0] bus_wdata,
    input logic [31:0] status,
    input logic [31:0] wcnt
);
    logic cmd_w, cnt_w;
    assign cmd_w = bus_en && bus_we && bus_sel == 2'd2;
    assign cnt_w = bus_en && bus_we && bus_sel == 2'd3;

    a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[7:0] == 8'h02) |=> (status[31] && !status[30]));

    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[7:0] == 8'h03) |=> (!status[31] && status[30]));

    a_r6_run_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31] && !cnt_w) |=> (wcnt == $past(wcnt) + 32'd1));

    a_r7_halted_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[31] && cmd_w && bus_wdata[7:0] == 8'h01 && !cnt_w)
        |=> (wcnt == $past(wcnt) + 32'd1));

    a_r9_pipe_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[7:0] == 8'h04) |=> status[23]);

    a_r10_prof_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[7:0] == 8'h0C) |=> status[29]);

    a_r12_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[31] && cmd_w && bus_wdata[7:0] == 8'h55 && !cnt_w)
        |=> ($stable(status) && $stable(wcnt)));
endmodule

bind engine_exec_ctrl eec_checker i_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .status(status_w), .wcnt(wcnt_w)
);

// File: tb/test_engine_exec_ctrl.sv
`timescale 1ns/1ps
module test_engine_exec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    engine_exec_ctrl i_engine_exec_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // {op(1=read), code, address, data or expected value}
    localparam int NV = 10;
    localparam logic [79:0] VEC [NV] = '{
        {8'd0, 8'h11, 32'h0000_0003, 32'hA5A5_0003},
        {8'd0, 8'h13, 32'h0000_0003, 32'h5A5A_0013},
        {8'd0, 8'h15, 32'h0000_0005, 32'h1234_5678},
        {8'd0, 8'h11, 32'h0000_0007, 32'hDEAD_BEEF},
        {8'd1, 8'h10, 32'h0000_0003, 32'hA5A5_0003},
        {8'd1, 8'h12, 32'h0000_0003, 32'h5A5A_0013},
        {8'd1, 8'h14, 32'h0000_0005, 32'h1234_5678},
        {8'd1, 8'h10, 32'h0000_0017, 32'hDEAD_BEEF},
        {8'd1, 8'h12, 32'h0000_0007, 32'h0000_0000},
        {8'd1, 8'h14, 32'h0000_0003, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        bus_sel = sel;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ind_read(input logic [7:0] code, input logic [31:0] a, output logic [31:0] d);
        wr(2'd1, a);
        wr(2'd2, {24'd0, code});
        idle(2);
        rd(2'd0, d);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, s0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd2, v); chk("R1 status", v, 32'h6080_0000);
        rd(2'd3, v); chk("R1 count", v, 32'd0);
        rd(2'd0, v); chk("R1 data", v, 32'd0);
        rd(2'd1, v); chk("R1 addr", v, 32'd0);

        wr(2'd0, 32'h0BAD_CAFE); rd(2'd0, v); chk("R2 data reg", v, 32'h0BAD_CAFE);
        wr(2'd1, 32'h8000_0011); rd(2'd1, v); chk("R2 addr reg", v, 32'h8000_0011);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][79:72] == 8'd0) begin
                wr(2'd0, VEC[i][31:0]);
                wr(2'd1, VEC[i][63:32]);
                wr(2'd2, {24'd0, VEC[i][71:64]});
            end else begin
                ind_read(VEC[i][71:64], VEC[i][63:32], v);
                chk($sformatf("R3 vector %0d", i), v, VEC[i][31:0]);
            end
        end

        // R4: the data register changes exactly at the second edge
        wr(2'd0, 32'hCAFE_F00D);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'h10);
        rd(2'd0, v); chk("R4 first edge", v, 32'hCAFE_F00D);
        idle(1); rd(2'd0, v); chk("R4 second edge", v, 32'hCAFE_F00D);
        idle(1); rd(2'd0, v); chk("R4 result", v, 32'hA5A5_0003);

        // R11 count write, R7 halted step, R9 pipeline flag
        wr(2'd3, 32'h0000_1234); rd(2'd3, v); chk("R11 count load", v, 32'h1234);
        wr(2'd3, 32'd0);
        wr(2'd2, 32'h01); rd(2'd3, v); chk("R7 halted step", v, 32'd1);
        rd(2'd2, v); chk("R9 pipe cleared by retire", {31'd0, v[23]}, 32'd0);
        wr(2'd2, 32'h01);
        ind_read(8'h14, 32'd0, v); chk("R8 pc advanced twice", v, 32'h0002_0000);
        wr(2'd2, 32'h04); rd(2'd2, v); chk("R9 pipe set", {31'd0, v[23]}, 32'd1);

        // R8 wrap of the next-PC field
        wr(2'd0, 32'h9FFF_0700); wr(2'd1, 32'd0); wr(2'd2, 32'h15);
        wr(2'd2, 32'h01);
        ind_read(8'h14, 32'd0, v); chk("R8 pc wrap", v, 32'h8000_0700);

        // R5/R6 running
        wr(2'd3, 32'd0);
        wr(2'd2, 32'h02);
        rd(2'd2, v); chk("R5 start flags", {30'd0, v[31:30]}, 32'd2);
        idle(5);
        wr(2'd2, 32'h03);
        rd(2'd3, v); chk("R6 run count", v, 32'd6);
        rd(2'd2, v); chk("R5 stop flags", {30'd0, v[31:30]}, 32'd1);
        idle(3);
        rd(2'd3, v); chk("R6 halted holds", v, 32'd6);

        // R7 step while running is ignored
        wr(2'd3, 32'd0);
        wr(2'd2, 32'h02);
        wr(2'd2, 32'h01);
        wr(2'd2, 32'h03);
        rd(2'd3, v); chk("R7 step ignored while running", v, 32'd2);

        // R10 profile flag
        rd(2'd2, v); chk("R10 profile nonzero", {31'd0, v[29]}, 32'd0);
        wr(2'd2, 32'h0C);
        rd(2'd2, v); chk("R10 profile cleared", {31'd0, v[29]}, 32'd1);

        // R12 unknown codes
        rd(2'd2, s0); rd(2'd3, c0);
        wr(2'd2, 32'h55);
        wr(2'd2, 32'h00);
        rd(2'd2, v); chk("R12 status unchanged", v, s0);
        rd(2'd3, v); chk("R12 count unchanged", v, c0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule